// File: doc/BRIEF.md
# Port Direction Arbiter

This block settles, for every pin of an 8-bit general-purpose port, whether the pad drives and how it drives. Software owns an 8-bit direction register on a plain register bus. Peripheral functions routed onto the upper four pins take precedence over that register whenever they are both routed and enabled. Those functions are a serial-peripheral master/slave, a two-wire bus controller, and four pulse-width channels.

Each of the upper pins walks a fixed chain of sources. The serial-peripheral function comes first and supplies its own per-pin direction request. The two-wire controller comes next and exists only on pins 7 and 4, where it forces an open-drain output. The pulse-width channel tied to the pin comes after that and forces a push-pull output. The software bit applies only when none of these is active. Pins 3 to 0 follow the software bit alone.

The register responds one clock after a write strobe. The pin resolution is purely combinational from the register and the peripheral inputs. There is no streaming data path, so every pin is a plain level signal with no valid/ready handshake and no back-pressure.

Top module: `pdir_arbiter`

## Requirements
- R1: A write with `bus_we` high and `bus_addr` equal to 0x024A loads `bus_wdata` into the direction register at that clock edge. A write to any other address leaves the register unchanged.
- R2: After reset every direction bit is 0, so every `pin_oe` bit is 0 and every `pin_od` bit is 0 while no peripheral is active.
- R3: On pins 7 to 4, with no peripheral override active, `pin_oe[p]` equals direction bit p, where 1 means output.
- R4: On pins 7 to 4, while `spi_route` and `spi_en` are both 1, `pin_oe[p]` equals `spi_dir_req[p-4]` and `pin_od[p]` is 0, whatever the other sources say.
- R5: On pins 7 and 4, while `iic_route` and `iic_en` are both 1 and the R4 override is not active, `pin_oe` and `pin_od` are both 1.
- R6: `pin_od[p]` is 1 only while the R5 override is active on pin p. Pins 6, 5 and 3 to 0 never assert it.
- R7: A read at 0x024A returns the stored software bits, not the effective directions. A read at any other address returns 0. Reads are combinational.
- R8: Channel k of `pwm_route`/`pwm_en` (k = 0..3) belongs to pin 4+k. When that channel is routed and enabled and neither R4 nor R5 applies to the pin, the pin gets `pin_oe` = 1 and `pin_od` = 0.
- R9: Pins 3 to 0 ignore every peripheral input. Their `pin_oe` equals the direction bit and their `pin_od` is 0.
- R10: A change on any peripheral input shows at `pin_oe`/`pin_od` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register bus address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| spi_route | input | 1 | Serial-peripheral function routed to this port |
| spi_en | input | 1 | Serial-peripheral function enabled |
| spi_dir_req | input | 4 | Serial-peripheral direction request for pins 7..4 (bit 0 = pin 4) |
| iic_route | input | 1 | Two-wire controller routed to this port |
| iic_en | input | 1 | Two-wire controller enabled |
| pwm_route | input | 4 | Pulse-width channel k routed to pin 4+k |
| pwm_en | input | 4 | Pulse-width channel k enabled |
| pin_oe | output | 8 | Effective output enable per pin |
| pin_od | output | 8 | Open-drain drive mode per pin |

## Verification
A register write is due one edge after the strobe, so the bench's model updates its copy of the register at that same posedge. The pin outputs and the read data are combinational, so they are due in the cycle the inputs change. The bench drives inputs just after the rising edge and compares every output against the model at the following falling edge. A separate directed check flips peripheral inputs in the low phase and samples one nanosecond later with no edge between, which shows that R10 involves no hidden register.

// File: rtl/pdir_pkg.sv
package pdir_pkg;
  localparam int PORT_W   = 8;
  localparam int PERIPH_LO = 4;
  localparam int PERIPH_N  = PORT_W - PERIPH_LO;

  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_SPI = 2'd1,
    SRC_IIC = 2'd2,
    SRC_PWM = 2'd3
  } dir_src_e;

  typedef struct packed {
    logic oe;
    logic od;
  } pin_drive_t;
endpackage

// File: rtl/pdir_reg.sv
module pdir_reg #(
  parameter int W      = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ADDR = 16'h024A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      dir_q
);
  logic hit;
  assign hit = (addr == ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dir_q <= '0;
    else if (we && hit) dir_q <= wdata;
  end

  assign rdata = hit ? dir_q : '0;

  // R1
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit) |=> (dir_q == $past(wdata)));
  // R1
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && hit) |=> $stable(dir_q));
endmodule

// File: rtl/pdir_decode.sv
module pdir_decode #(
  parameter int PORT_W    = 8,
  parameter int PERIPH_LO = 4,
  parameter logic [PORT_W-1:0] IIC_MASK = 8'h90,
  localparam int PERIPH_N = PORT_W - PERIPH_LO
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_route,
  input  logic                spi_en,
  input  logic [PERIPH_N-1:0] spi_dir_req,
  input  logic                iic_route,
  input  logic                iic_en,
  input  logic [PERIPH_N-1:0] pwm_route,
  input  logic [PERIPH_N-1:0] pwm_en,
  output logic [PORT_W-1:0]   spi_act,
  output logic [PORT_W-1:0]   spi_req,
  output logic [PORT_W-1:0]   iic_act,
  output logic [PORT_W-1:0]   pwm_act
);
  logic spi_on, iic_on;
  assign spi_on = spi_route & spi_en;
  assign iic_on = iic_route & iic_en;

  for (genvar p = 0; p < PORT_W; p++) begin : g_pin
    if (p >= PERIPH_LO) begin : g_hi
      assign spi_act[p] = spi_on;
      assign spi_req[p] = spi_dir_req[p-PERIPH_LO];
      assign pwm_act[p] = pwm_route[p-PERIPH_LO] & pwm_en[p-PERIPH_LO];
      assign iic_act[p] = IIC_MASK[p] & iic_on;
    end else begin : g_lo
      assign spi_act[p] = 1'b0;
      assign spi_req[p] = 1'b0;
      assign pwm_act[p] = 1'b0;
      assign iic_act[p] = 1'b0;
    end
  end

  // R9
  lo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((spi_act | iic_act | pwm_act) & PORT_W'((1 << PERIPH_LO) - 1)) == '0);
endmodule

// File: rtl/pdir_resolve.sv
module pdir_resolve
  import pdir_pkg::*;
#(
  parameter bit HAS_SPI = 1'b1,
  parameter bit HAS_IIC = 1'b0,
  parameter bit HAS_PWM = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_dir,
  input  logic       spi_act,
  input  logic       spi_req,
  input  logic       iic_act,
  input  logic       pwm_act,
  output pin_drive_t drv
);
  dir_src_e src;

  always_comb begin
    if (HAS_SPI && spi_act)      src = SRC_SPI;
    else if (HAS_IIC && iic_act) src = SRC_IIC;
    else if (HAS_PWM && pwm_act) src = SRC_PWM;
    else                         src = SRC_SW;
  end

  always_comb begin
    unique case (src)
      SRC_SPI: drv = '{oe: spi_req, od: 1'b0};
      SRC_IIC: drv = '{oe: 1'b1,    od: 1'b1};
      SRC_PWM: drv = '{oe: 1'b1,    od: 1'b0};
      default: drv = '{oe: sw_dir,  od: 1'b0};
    endcase
  end

  // R4
  spi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_SPI && spi_act) |-> (drv.oe == spi_req && !drv.od));
  // R6
  od_needs_iic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv.od |-> (HAS_IIC && iic_act && drv.oe));
  // R8
  pwm_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_PWM && pwm_act && !spi_act && !(HAS_IIC && iic_act)) |-> (drv.oe && !drv.od));
  // R3
  sw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_act && !iic_act && !pwm_act) |-> (drv.oe == sw_dir));
endmodule

// File: rtl/pdir_arbiter.sv
module pdir_arbiter
  import pdir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 16'h024A,
  parameter logic [PORT_W-1:0] IIC_MASK = 8'h90
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [PORT_W-1:0]   bus_wdata,
  output logic [PORT_W-1:0]   bus_rdata,
  input  logic                spi_route,
  input  logic                spi_en,
  input  logic [PERIPH_N-1:0] spi_dir_req,
  input  logic                iic_route,
  input  logic                iic_en,
  input  logic [PERIPH_N-1:0] pwm_route,
  input  logic [PERIPH_N-1:0] pwm_en,
  output logic [PORT_W-1:0]   pin_oe,
  output logic [PORT_W-1:0]   pin_od
);
  logic [PORT_W-1:0] dir_q, spi_act, spi_req, iic_act, pwm_act;

  pdir_reg #(.W(PORT_W), .ADDR_W(ADDR_W), .ADDR(DIR_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .rdata(bus_rdata), .dir_q(dir_q)
  );

  pdir_decode #(.PORT_W(PORT_W), .PERIPH_LO(PERIPH_LO), .IIC_MASK(IIC_MASK)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .spi_route(spi_route), .spi_en(spi_en), .spi_dir_req(spi_dir_req),
    .iic_route(iic_route), .iic_en(iic_en),
    .pwm_route(pwm_route), .pwm_en(pwm_en),
    .spi_act(spi_act), .spi_req(spi_req), .iic_act(iic_act), .pwm_act(pwm_act)
  );

  for (genvar p = 0; p < PORT_W; p++) begin : g_res
    pin_drive_t drv;
    pdir_resolve #(
      .HAS_SPI(p >= PERIPH_LO),
      .HAS_IIC(IIC_MASK[p]),
      .HAS_PWM(p >= PERIPH_LO)
    ) u_res (
      .clk(clk), .rst_n(rst_n), .sw_dir(dir_q[p]),
      .spi_act(spi_act[p]), .spi_req(spi_req[p]),
      .iic_act(iic_act[p]), .pwm_act(pwm_act[p]), .drv(drv)
    );
    assign pin_oe[p] = drv.oe;
    assign pin_od[p] = drv.od;
  end

  // R5
  iic_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iic_route && iic_en && !(spi_route && spi_en)) |-> ((pin_oe & IIC_MASK) == IIC_MASK));
  // R6
  od_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_od & ~IIC_MASK) == '0);
endmodule

// File: tb/pdir_arbiter_bench.sv
`timescale 1ns/1ps
module pdir_arbiter_bench;
  localparam logic [15:0] A = 16'h024A;

  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr = 0;
  logic bus_we = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic spi_route = 0, spi_en = 0, iic_route = 0, iic_en = 0;
  logic [3:0] spi_dir_req = 0, pwm_route = 0, pwm_en = 0;
  logic [7:0] pin_oe, pin_od;

  int tests = 0, fails = 0;
  logic [7:0] sw_m = 0;
  bit compare_on = 0;

  always #2.5 clk = ~clk;

  pdir_arbiter u_pdir_arbiter (.*);

  // reference copy of the software register
  always @(posedge clk or negedge rst_n)
    if (!rst_n) sw_m <= 0;
    else if (bus_we && bus_addr == A) sw_m <= bus_wdata;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int p = 0; p < 8; p++) begin
      logic eo, ed;
      string t;
      if (p >= 4 && spi_route && spi_en) begin eo = spi_dir_req[p-4]; ed = 0; t = "R4"; end
      else if ((p == 7 || p == 4) && iic_route && iic_en) begin eo = 1; ed = 1; t = "R5"; end
      else if (p >= 4 && pwm_route[p-4] && pwm_en[p-4]) begin eo = 1; ed = 0; t = "R8"; end
      else begin eo = sw_m[p]; ed = 0; t = (p < 4) ? "R9" : "R3"; end
      check(t, pin_oe[p], eo);
      check("R6", pin_od[p], ed);
    end
    check("R7", bus_rdata, (bus_addr == A) ? sw_m : 8'h00);
  endtask

  always @(negedge clk) if (compare_on) compare_all();

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_we = 1; bus_wdata = d; step(); bus_we = 0; bus_addr = A;
  endtask

  task automatic clr_periph();
    spi_route = 0; spi_en = 0; iic_route = 0; iic_en = 0;
    pwm_route = 0; pwm_en = 0; spi_dir_req = 0;
  endtask

  initial begin : watchdog
    #500000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bus_addr = A;
    #12 rst_n = 1;
    step();
    // R2 reset state
    check("R2", pin_oe, 8'h00);
    check("R2", pin_od, 8'h00);
    check("R2", bus_rdata, 8'h00);
    compare_on = 1;

    // R1 write lands next edge; R7 readback
    wr(A, 8'hA5);
    @(negedge clk); check("R1", bus_rdata, 8'hA5); check("R3", pin_oe, 8'hA5);
    step();
    wr(A + 16'd1, 8'h3C);
    @(negedge clk); check("R1", bus_rdata, 8'hA5);
    bus_addr = A + 16'd1; #1 check("R7", bus_rdata, 8'h00); bus_addr = A;
    step();

    // R4 SPI beats IIC and PWM; R7 readback unchanged by override
    spi_route = 1; spi_en = 1; iic_route = 1; iic_en = 1;
    pwm_route = 4'hF; pwm_en = 4'hF; spi_dir_req = 4'b0110;
    @(negedge clk);
    check("R4", pin_oe, 8'h65); check("R4", pin_od, 8'h00);
    check("R7", bus_rdata, 8'hA5);
    step();

    // R5 IIC on pins 7/4, PWM on 6/5
    spi_en = 0;
    @(negedge clk);
    check("R5", pin_oe, 8'hF5); check("R5", pin_od, 8'h90);
    step();

    // R8 PWM only; route without enable does nothing
    iic_en = 0; pwm_en = 4'b0101; wr(A, 8'h00);
    @(negedge clk);
    check("R8", pin_oe, 8'h50); check("R6", pin_od, 8'h00);
    step();

    // R9 low pins ignore peripherals
    wr(A, 8'h0F); spi_en = 1; spi_dir_req = 0; iic_en = 1;
    @(negedge clk); check("R9", pin_oe & 8'h0F, 8'h0F);
    step();

    // R10 combinational: change in low phase, no edge between
    clr_periph(); wr(A, 8'h00);
    @(negedge clk); #0.5;
    iic_route = 1; iic_en = 1; #1;
    check("R10", pin_od, 8'h90);
    pwm_route = 4'h2; pwm_en = 4'h2; iic_en = 0; #1;
    check("R10", pin_oe, 8'h20);
    step();
    clr_periph();

    // randomized traffic with per-clock model compare
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      bus_we = r[0]; bus_addr = r[1] ? A : (r[2] ? A + 16'd2 : 16'h0000);
      bus_wdata = r[15:8];
      spi_route = r[16]; spi_en = r[17] & r[18]; spi_dir_req = r[22:19];
      iic_route = r[23]; iic_en = r[24];
      pwm_route = r[28:25]; pwm_en = {r[29], r[30], r[31], r[5]};
      step();
    end
    bus_we = 0; clr_periph();
    step();

    // R2 reset mid-run clears register
    wr(A, 8'hFF);
    compare_on = 0;
    rst_n = 0; #1;
    check("R2", pin_oe, 8'h00); check("R2", bus_rdata, 8'h00);
    step(); rst_n = 1; step();
    compare_on = 1;
    step(); step();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule